// File: doc/BRIEF.md
# Power-Down Mode Controller

This block sequences a small microcontroller between normal operation and four low-power conditions. A sleep strobe from the CPU enters either a light sleep or a deeper software standby. The choice comes from a select bit in a local control register. Separate per-peripheral stop bits gate single modules while the rest of the chip runs. An active-low standby pin forces a full hardware standby that only a power-on reset ends.

The block drives clock enables for the clock generator, the CPU, each generic peripheral, the real-time clock and the timer unit. It tells the memory controller whether to keep normal refresh or switch to self-refresh. It reports the present mode on a two-bit status output. On an interrupt, software standby returns through an oscillator-settling wait of programmable length. During that wait the clock generator runs and the CPU stays stopped. CPU registers and on-chip memory are never cleared by any mode; only the clock enables change.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: From run mode, a `sleepStrobe` with the standby-select bit (control register bit 7) at 0 gives sleep mode on the next clock. The CPU clock is off, the clock generator and unstopped peripherals keep running, and `selfRefresh` stays 0.
- R2: From run mode, a `sleepStrobe` with the standby-select bit at 1 gives software standby on the next clock. The clock generator, CPU and generic peripheral enables are all 0, and `selfRefresh` is 1.
- R3: In sleep mode, `irqReq` or `sysRst` returns the block to run mode on the next clock.
- R4: In software standby, `sysRst` returns to run mode on the next clock. `irqReq` instead starts a settling wait of N+1 cycles, where N is the settle register. During the wait the clock generator runs, the CPU and peripherals stay off, self-refresh is held and the status stays 10. Run mode follows the wait.
- R5: Control register bits [NUM_MOD-1:0] are per-module stop bits. A set bit forces that `modClkEn` bit to 0 from the next clock while the CPU keeps running. Clearing the bit restores the enable.
- R6: `hwStbyN` passes through a two-flop synchroniser. A low level enters hardware standby on the third rising edge, from any mode and ahead of any other request. In hardware standby every clock enable is 0 and `selfRefresh` is 1.
- R7: Hardware standby is left only through `porRstN`. Neither `irqReq`, `sysRst`, `sleepStrobe` nor a return of `hwStbyN` to 1 changes the mode.
- R8: `rtcClkEn` equals the RTC start bit (register 2 bit 0) in every mode except hardware standby, where it is 0.
- R9: `tmrClkEn` is 1 in run mode. In sleep mode it equals the timer-from-RTC bit (register 2 bit 1). In both standby modes it is 0.
- R10: Register map by `regAddr`: 0 = control (bit 7 select, low bits stop), 1 = settle count, 2 = RTC start (bit 0) and timer-from-RTC (bit 1), 3 = reads 0 and ignores writes. A write lands on the clock edge with `regWe`, and reads are combinational. `porRstN` clears every register and `sysRst` clears none.
- R11: `modeStat` encodes 00 run, 01 sleep, 10 software standby (including the settling wait) and 11 hardware standby. `cpuClkEn` is 1 only in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| porRstN | input | 1 | Asynchronous power-on reset, active low |
| sysRst | input | 1 | Synchronous reset request, wakes from sleep or software standby |
| sleepStrobe | input | 1 | One-cycle sleep instruction strobe |
| irqReq | input | 1 | Pending interrupt request |
| hwStbyN | input | 1 | Asynchronous hardware standby pin, active low |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| modeStat | output | 2 | Present mode code |
| cpgClkEn | output | 1 | Clock generator enable |
| cpuClkEn | output | 1 | CPU clock enable |
| modClkEn | output | NUM_MOD | Generic peripheral clock enables |
| rtcClkEn | output | 1 | Real-time clock keep-alive |
| tmrClkEn | output | 1 | Timer unit clock enable |
| selfRefresh | output | 1 | 1 selects memory self-refresh, 0 normal refresh |

## Verification
The bench uses the defaults: four generic modules and an eight-bit settling counter. With these values every stop-bit pattern, including mixed ones, sits next to all four modes. A settle value of 255 runs the counter across its whole range in 256 cycles, and a value of 0 tests the shortest wait. The narrow counter also makes the zero and full-scale ends cheap to reach in a short run.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    PS_RUN    = 3'd0,
    PS_SLEEP  = 3'd1,
    PS_SWSTBY = 3'd2,
    PS_SETTLE = 3'd3,
    PS_HWSTBY = 3'd4
  } pwrState_t;

  typedef struct packed {
    logic loadSettle;
    logic decSettle;
  } dpStrobe_t;

  localparam int REG_W        = 8;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_SETTLE = 2'd1;
  localparam logic [1:0] ADDR_AUX    = 2'd2;
  localparam int SEL_BIT      = 7;
endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int NUM_MOD  = 4,
  parameter int SETTLE_W = 8
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               hwStbyN,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  logic [REG_W-1:0]   regWdata,
  input  dpStrobe_t          strobe,
  input  pwrState_t          state,
  output logic [REG_W-1:0]   regRdata,
  output logic               hwReq,
  output logic               stbySel,
  output logic               settleDone,
  output logic [1:0]         modeStat,
  output logic               cpgClkEn,
  output logic               cpuClkEn,
  output logic [NUM_MOD-1:0] modClkEn,
  output logic               rtcClkEn,
  output logic               tmrClkEn,
  output logic               selfRefresh
);
  logic [1:0]          hwSync;
  logic [NUM_MOD-1:0]  stopBits;
  logic [SETTLE_W-1:0] settleVal;
  logic [SETTLE_W-1:0] settleCnt;
  logic                rtcStart;
  logic                tmrFromRtc;
  logic                periphOn;
  logic [REG_W-1:0]    ctrlWord;
  logic [REG_W-1:0]    settleWord;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) hwSync <= 2'b11;
    else          hwSync <= {hwSync[0], hwStbyN};
  end
  assign hwReq = ~hwSync[1];

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      stopBits   <= '0;
      stbySel    <= 1'b0;
      settleVal  <= '0;
      rtcStart   <= 1'b0;
      tmrFromRtc <= 1'b0;
    end else if (regWe) begin
      case (regAddr)
        ADDR_CTRL: begin
          stopBits <= regWdata[NUM_MOD-1:0];
          stbySel  <= regWdata[SEL_BIT];
        end
        ADDR_SETTLE: settleVal <= regWdata[SETTLE_W-1:0];
        ADDR_AUX: begin
          rtcStart   <= regWdata[0];
          tmrFromRtc <= regWdata[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)              settleCnt <= '0;
    else if (strobe.loadSettle) settleCnt <= settleVal;
    else if (strobe.decSettle)  settleCnt <= settleCnt - 1'b1;
  end
  assign settleDone = (settleCnt == '0);

  always_comb begin
    ctrlWord = '0;
    ctrlWord[SEL_BIT] = stbySel;
    ctrlWord[NUM_MOD-1:0] = stopBits;
    settleWord = '0;
    settleWord[SETTLE_W-1:0] = settleVal;
    case (regAddr)
      ADDR_CTRL:   regRdata = ctrlWord;
      ADDR_SETTLE: regRdata = settleWord;
      ADDR_AUX:    regRdata = {{(REG_W-2){1'b0}}, tmrFromRtc, rtcStart};
      default:     regRdata = '0;
    endcase
  end

  assign periphOn = (state == PS_RUN) || (state == PS_SLEEP);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_MOD; gi++) begin : g_mod
      assign modClkEn[gi] = periphOn & ~stopBits[gi];
    end
  endgenerate

  always_comb begin
    cpuClkEn    = (state == PS_RUN);
    cpgClkEn    = periphOn || (state == PS_SETTLE);
    selfRefresh = !periphOn;
    rtcClkEn    = rtcStart && (state != PS_HWSTBY);
    case (state)
      PS_RUN:   tmrClkEn = 1'b1;
      PS_SLEEP: tmrClkEn = tmrFromRtc;
      default:  tmrClkEn = 1'b0;
    endcase
    case (state)
      PS_RUN:    modeStat = 2'b00;
      PS_SLEEP:  modeStat = 2'b01;
      PS_HWSTBY: modeStat = 2'b11;
      default:   modeStat = 2'b10;
    endcase
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      porRstN,
  input  logic      sleepStrobe,
  input  logic      irqReq,
  input  logic      sysRst,
  input  logic      hwReq,
  input  logic      stbySel,
  input  logic      settleDone,
  output pwrState_t state,
  output dpStrobe_t strobe
);
  pwrState_t nextState;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) state <= PS_RUN;
    else          state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (state == PS_HWSTBY) begin
      nextState = PS_HWSTBY;
    end else if (hwReq) begin
      nextState = PS_HWSTBY;
    end else begin
      case (state)
        PS_RUN:
          if (!sysRst && sleepStrobe) nextState = stbySel ? PS_SWSTBY : PS_SLEEP;
        PS_SLEEP:
          if (sysRst || irqReq) nextState = PS_RUN;
        PS_SWSTBY:
          if (sysRst) nextState = PS_RUN;
          else if (irqReq) begin
            nextState = PS_SETTLE;
            strobe.loadSettle = 1'b1;
          end
        PS_SETTLE:
          if (sysRst || settleDone) nextState = PS_RUN;
          else strobe.decSettle = 1'b1;
        default: nextState = PS_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_MOD  = 4,
  parameter int SETTLE_W = 8
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               sysRst,
  input  logic               sleepStrobe,
  input  logic               irqReq,
  input  logic               hwStbyN,
  input  logic               regWe,
  input  logic [1:0]         regAddr,
  input  logic [7:0]         regWdata,
  output logic [7:0]         regRdata,
  output logic [1:0]         modeStat,
  output logic               cpgClkEn,
  output logic               cpuClkEn,
  output logic [NUM_MOD-1:0] modClkEn,
  output logic               rtcClkEn,
  output logic               tmrClkEn,
  output logic               selfRefresh
);
  pwrState_t state;
  dpStrobe_t strobe;
  logic      hwReq;
  logic      stbySel;
  logic      settleDone;

  pwr_mode_fsm fsm_i (
    .clk(clk), .porRstN(porRstN), .sleepStrobe(sleepStrobe), .irqReq(irqReq),
    .sysRst(sysRst), .hwReq(hwReq), .stbySel(stbySel), .settleDone(settleDone),
    .state(state), .strobe(strobe)
  );

  pwr_mode_dp #(.NUM_MOD(NUM_MOD), .SETTLE_W(SETTLE_W)) dp_i (
    .clk(clk), .porRstN(porRstN), .hwStbyN(hwStbyN), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .strobe(strobe), .state(state),
    .regRdata(regRdata), .hwReq(hwReq), .stbySel(stbySel), .settleDone(settleDone),
    .modeStat(modeStat), .cpgClkEn(cpgClkEn), .cpuClkEn(cpuClkEn),
    .modClkEn(modClkEn), .rtcClkEn(rtcClkEn), .tmrClkEn(tmrClkEn),
    .selfRefresh(selfRefresh)
  );
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
  parameter int NUM_MOD = 4
) (
  input logic               clk,
  input logic               porRstN,
  input logic               sysRst,
  input logic               sleepStrobe,
  input logic               irqReq,
  input logic               hwReq,
  input logic               stbySel,
  input logic [1:0]         modeStat,
  input logic               cpgClkEn,
  input logic               cpuClkEn,
  input logic [NUM_MOD-1:0] modClkEn,
  input logic               selfRefresh
);
  assert_sleep_entry_R1: assert property (@(posedge clk) disable iff (!porRstN)
    (modeStat == 2'b00 && sleepStrobe && !stbySel && !hwReq && !sysRst)
      |=> (modeStat == 2'b01 && cpgClkEn && !selfRefresh));

  assert_stby_entry_R2: assert property (@(posedge clk) disable iff (!porRstN)
    (modeStat == 2'b00 && sleepStrobe && stbySel && !hwReq && !sysRst)
      |=> (modeStat == 2'b10 && !cpgClkEn && selfRefresh && modClkEn == '0));

  assert_sleep_exit_R3: assert property (@(posedge clk) disable iff (!porRstN)
    (modeStat == 2'b01 && (irqReq || sysRst) && !hwReq) |=> (modeStat == 2'b00));

  assert_stby_gates_R4: assert property (@(posedge clk) disable iff (!porRstN)
    (modeStat == 2'b10) |-> (!cpuClkEn && selfRefresh && modClkEn == '0));

  assert_hw_priority_R6: assert property (@(posedge clk) disable iff (!porRstN)
    hwReq |=> (modeStat == 2'b11));

  assert_hw_hold_R7: assert property (@(posedge clk) disable iff (!porRstN)
    (modeStat == 2'b11) |=> (modeStat == 2'b11 && !cpgClkEn && selfRefresh));

  assert_cpu_run_only_R11: assert property (@(posedge clk) disable iff (!porRstN)
    cpuClkEn |-> (modeStat == 2'b00 && cpgClkEn && !selfRefresh));
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.NUM_MOD(NUM_MOD)) chk_i (
  .clk(clk), .porRstN(porRstN), .sysRst(sysRst), .sleepStrobe(sleepStrobe),
  .irqReq(irqReq), .hwReq(hwReq), .stbySel(stbySel), .modeStat(modeStat),
  .cpgClkEn(cpgClkEn), .cpuClkEn(cpuClkEn), .modClkEn(modClkEn),
  .selfRefresh(selfRefresh)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  localparam int NUM_MOD = 4;

  logic clk = 1'b0;
  logic porRstN = 1'b0;
  logic sysRst = 1'b0, sleepStrobe = 1'b0, irqReq = 1'b0, hwStbyN = 1'b1;
  logic regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic [1:0] modeStat;
  logic cpgClkEn, cpuClkEn, rtcClkEn, tmrClkEn, selfRefresh;
  logic [NUM_MOD-1:0] modClkEn;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R11";

  // behavioural reference state: 0 run, 1 sleep, 2 sw standby, 3 settling, 4 hw standby
  int mMode = 0, mCnt = 0;
  logic mS1 = 1'b1, mS2 = 1'b1;
  logic [NUM_MOD-1:0] mStop = '0;
  logic mSel = 1'b0, mRtc = 1'b0, mTmr = 1'b0;
  logic [7:0] mSettle = 8'd0;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.NUM_MOD(NUM_MOD), .SETTLE_W(8)) dut_i (
    .clk(clk), .porRstN(porRstN), .sysRst(sysRst), .sleepStrobe(sleepStrobe),
    .irqReq(irqReq), .hwStbyN(hwStbyN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .modeStat(modeStat),
    .cpgClkEn(cpgClkEn), .cpuClkEn(cpuClkEn), .modClkEn(modClkEn),
    .rtcClkEn(rtcClkEn), .tmrClkEn(tmrClkEn), .selfRefresh(selfRefresh)
  );

  always @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      mMode = 0; mCnt = 0; mS1 = 1'b1; mS2 = 1'b1;
      mStop = '0; mSel = 1'b0; mRtc = 1'b0; mTmr = 1'b0; mSettle = 8'd0;
    end else begin
      bit req;
      req = !mS2;
      mS2 = mS1;
      mS1 = hwStbyN;
      if (mMode == 4) mMode = 4;
      else if (req) mMode = 4;
      else if (mMode == 0) begin
        if (!sysRst && sleepStrobe) mMode = mSel ? 2 : 1;
      end else if (mMode == 1) begin
        if (sysRst || irqReq) mMode = 0;
      end else if (mMode == 2) begin
        if (sysRst) mMode = 0;
        else if (irqReq) begin mMode = 3; mCnt = mSettle; end
      end else begin
        if (sysRst || mCnt == 0) mMode = 0;
        else mCnt = mCnt - 1;
      end
      if (regWe) begin
        if (regAddr == 2'd0) begin mStop = regWdata[NUM_MOD-1:0]; mSel = regWdata[7]; end
        else if (regAddr == 2'd1) mSettle = regWdata;
        else if (regAddr == 2'd2) begin mRtc = regWdata[0]; mTmr = regWdata[1]; end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int eStat;
      logic [NUM_MOD-1:0] eMod;
      eStat = (mMode == 0) ? 0 : (mMode == 1) ? 1 : (mMode == 4) ? 3 : 2;
      eMod  = (mMode <= 1) ? ~mStop : '0;
      chk(modeStat == eStat, phase, "modeStat", modeStat, eStat);
      chk(cpuClkEn == (mMode == 0), phase, "cpuClkEn", cpuClkEn, mMode == 0);
      chk(cpgClkEn == (mMode <= 1 || mMode == 3), phase, "cpgClkEn", cpgClkEn,
          mMode <= 1 || mMode == 3);
      chk(modClkEn == eMod, phase, "modClkEn", modClkEn, eMod);
      chk(selfRefresh == (mMode >= 2), phase, "selfRefresh", selfRefresh, mMode >= 2);
      chk(rtcClkEn == (mRtc && mMode != 4), phase, "rtcClkEn R8", rtcClkEn, mRtc && mMode != 4);
      chk(tmrClkEn == ((mMode == 0) || (mMode == 1 && mTmr)), phase, "tmrClkEn R9",
          tmrClkEn, (mMode == 0) || (mMode == 1 && mTmr));
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    sleepStrobe = 1'b0; irqReq = 1'b0; sysRst = 1'b0; regWe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1; tick();
  endtask

  task automatic rdChk(input logic [1:0] a);
    logic [7:0] e;
    regAddr = a; #3;
    case (a)
      2'd0: begin e = 8'd0; e[7] = mSel; e[NUM_MOD-1:0] = mStop; end
      2'd1: e = mSettle;
      2'd2: e = {6'd0, mTmr, mRtc};
      default: e = 8'd0;
    endcase
    chk(regRdata == e, "R10", "regRdata", regRdata, e);
  endtask

  task automatic por();
    porRstN = 1'b0; idle(2); porRstN = 1'b1; idle(1);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    phase = "R11"; por(); idle(2);
    phase = "R10";
    for (int a = 0; a < 4; a++) rdChk(2'(a));
    wrReg(2'd1, 8'd5); wrReg(2'd2, 8'h03); wrReg(2'd0, 8'h00); wrReg(2'd3, 8'hFF);
    for (int a = 0; a < 4; a++) rdChk(2'(a));

    phase = "R1"; sleepStrobe = 1; tick(); idle(3);
    phase = "R3"; irqReq = 1; tick(); idle(2);
    phase = "R1"; sleepStrobe = 1; tick(); idle(2);
    phase = "R3"; sysRst = 1; tick(); idle(2);
    phase = "R9"; wrReg(2'd2, 8'h01); sleepStrobe = 1; tick(); idle(2); irqReq = 1; tick();
    phase = "R8"; wrReg(2'd2, 8'h00); sleepStrobe = 1; tick(); idle(2); irqReq = 1; tick();
    wrReg(2'd2, 8'h01);

    phase = "R2"; wrReg(2'd0, 8'h80); sleepStrobe = 1; tick(); idle(4);
    phase = "R4"; irqReq = 1; tick(); idle(10);
    phase = "R2"; sleepStrobe = 1; tick(); idle(2);
    phase = "R4"; sysRst = 1; tick(); idle(2);
    wrReg(2'd1, 8'd0); sleepStrobe = 1; tick(); idle(2); irqReq = 1; tick(); idle(3);
    wrReg(2'd1, 8'd255); sleepStrobe = 1; tick(); idle(2); irqReq = 1; tick(); idle(260);
    phase = "R10"; sysRst = 1; tick(); rdChk(2'd0); rdChk(2'd1);

    phase = "R5"; wrReg(2'd0, 8'h05); idle(3); wrReg(2'd0, 8'h0A); sleepStrobe = 1; tick();
    idle(2); irqReq = 1; tick(); wrReg(2'd0, 8'h00); idle(3);

    phase = "R6"; sleepStrobe = 1; tick(); hwStbyN = 0; idle(5);
    phase = "R7"; irqReq = 1; tick(); sysRst = 1; tick(); sleepStrobe = 1; tick();
    hwStbyN = 1; idle(5);
    phase = "R10"; por(); for (int a = 0; a < 3; a++) rdChk(2'(a));
    idle(3);
    phase = "R6"; wrReg(2'd2, 8'h01); sleepStrobe = 1; hwStbyN = 0; tick(); idle(2);
    hwStbyN = 1; idle(4);
    phase = "R7"; por(); idle(3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule